// File: doc/BRIEF.md
# Alternating-Reload PWM Timer

This block is a pair of 16-bit down-counters that produce a pulse-width waveform. The primary counter reloads from register A and register B in turn. Each time it passes zero, it toggles the output pin, so A sets the length of one phase and B the length of the other. A secondary counter reloads from its own register and raises a flag each time it passes zero. Both counters are clocked either by a free-running prescaler on the system clock or by synchronized rising edges on an external event pin. Each counter has its own selector.

Software sets the starting level of the pin through a level bit while the primary counter is stopped. It then starts the counter by writing a non-zero select code. Three sticky pending flags report reloads from A, reloads from B and secondary underflows. Each flag is cleared by a one-cycle strobe. The register bus sits outside this block, and every register value arrives on a plain port.

Top module: `pwm_alt_timer`

## Requirements
- R1: The prescaler produces one tick every prescale+1 system clock cycles, for a factor of 1 to 32. It runs freely from reset.
- R2: A select code of 000 stops a counter. While the primary select is 000, the primary count is held at 0, the next reload source is set to A, and the pin takes the level bit on each clock. Codes 011 to 111 give no ticks and hold all counter state.
- R3: Select code 001 clocks a counter from the prescaler tick. On each underflow of the primary counter, the pin inverts when the output enable is 1.
- R4: On an underflow while the output enable is 0, the pin keeps its level. Reloading and flag setting still take place.
- R5: Underflow is the tick that finds the count at 0 and loads the reload value. The first reload after a start comes from A, and reloads then alternate B, A, B and so on. The pin therefore holds for A+1 ticks after an A reload and for B+1 ticks after a B reload.
- R6: A primary reload from A sets flag pend_a. A primary reload from B sets flag pend_b.
- R7: The secondary counter underflows every reload_sec+1 ticks, and each underflow sets pend_s.
- R8: Select code 010 clocks a counter from the event pin. The pin passes through two synchronizer flops. Each rising edge gives one tick, in the third clock cycle after the edge is first sampled.
- R9: Each flag stays set until a one-cycle clear strobe clears it. A set and a clear in the same cycle leave the flag set.
- R10: Reset clears the prescaler, both counters, the pin and all three flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale | input | 5 | Prescale value; divide factor is value+1 |
| sel_pri | input | 3 | Primary counter clock select |
| sel_sec | input | 3 | Secondary counter clock select |
| evt_pin | input | 1 | External event input, asynchronous |
| reload_a | input | 16 | Primary reload value for phase A |
| reload_b | input | 16 | Primary reload value for phase B |
| reload_sec | input | 16 | Secondary reload value |
| out_en | input | 1 | Enables pin toggling on primary underflow |
| init_level | input | 1 | Pin level loaded while primary is stopped |
| clr_a | input | 1 | Clear strobe for pend_a |
| clr_b | input | 1 | Clear strobe for pend_b |
| clr_s | input | 1 | Clear strobe for pend_s |
| pwm_out | output | 1 | PWM output pin |
| pend_a | output | 1 | Pending flag: reload from A |
| pend_b | output | 1 | Pending flag: reload from B |
| pend_s | output | 1 | Pending flag: secondary underflow |

## Verification
The hardest case to reach is a reload that sets a flag in the same cycle as a clear strobe for that flag. This requires knowing the exact cycle of the reload. The stimulus sets both reload values to zero with the prescale factor at one. The primary counter then reloads on every cycle and alternates between A and B. Holding a clear strobe high across that stretch lands clears on set cycles and on idle cycles alike, and the reference model predicts the flag level on every clock.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [2:0] SEL_STOP = 3'b000;
  localparam logic [2:0] SEL_PRE  = 3'b001;
  localparam logic [2:0] SEL_EVT  = 3'b010;

  // choose the count tick for a select code
  function automatic logic pick_tick(logic [2:0] sel, logic pre, logic evt);
    case (sel)
      SEL_PRE: return pre;
      SEL_EVT: return evt;
      default: return 1'b0;
    endcase
  endfunction

  // sticky flag: set has priority over clear
  function automatic logic next_flag(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  output logic          tick
);
  logic [PW-1:0] pcnt;

  assign tick = (pcnt == prescale);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pcnt <= '0;
    else if (tick) pcnt <= '0;
    else           pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr_evt_sync.sv
module tmr_evt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic tick
);
  localparam int DW = STAGES + 1;
  logic [DW-1:0] sh;

  assign tick = sh[STAGES-1] & ~sh[STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[DW-2:0], pin};
  end
endmodule

// File: rtl/tmr_alt_ctr.sv
module tmr_alt_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         tick,
  input  logic         out_en,
  input  logic         init_level,
  input  logic [W-1:0] rel_a,
  input  logic [W-1:0] rel_b,
  output logic         pwm,
  output logic         uf,
  output logic         set_a,
  output logic         set_b,
  output logic         src_b
);
  logic [W-1:0] cnt;

  assign uf    = tick & (cnt == '0);
  assign set_a = uf & ~src_b;
  assign set_b = uf & src_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      src_b <= 1'b0;
      pwm   <= 1'b0;
    end else if (stop) begin
      cnt   <= '0;
      src_b <= 1'b0;
      pwm   <= init_level;
    end else if (uf) begin
      cnt   <= src_b ? rel_b : rel_a;
      src_b <= ~src_b;
      if (out_en) pwm <= ~pwm;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/tmr_down_ctr.sv
module tmr_down_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         tick,
  input  logic [W-1:0] rel,
  output logic         uf
);
  logic [W-1:0] cnt;

  assign uf = tick & (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (stop) cnt <= '0;
    else if (uf)   cnt <= rel;
    else if (tick) cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/pwm_alt_timer.sv
module pwm_alt_timer #(
  parameter int W  = 16,
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] prescale,
  input  logic [2:0]    sel_pri,
  input  logic [2:0]    sel_sec,
  input  logic          evt_pin,
  input  logic [W-1:0]  reload_a,
  input  logic [W-1:0]  reload_b,
  input  logic [W-1:0]  reload_sec,
  input  logic          out_en,
  input  logic          init_level,
  input  logic          clr_a,
  input  logic          clr_b,
  input  logic          clr_s,
  output logic          pwm_out,
  output logic          pend_a,
  output logic          pend_b,
  output logic          pend_s
);
  import tmr_pkg::*;
  localparam int NFLAG = 3;

  logic tick_pre, tick_evt, tick_pri, tick_sec;
  logic uf_pri, uf_sec, set_a, set_b, src_b;
  logic [NFLAG-1:0] f_set, f_clr, f_q;

  tmr_prescale #(.PW(PW)) u_pre (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .tick(tick_pre));

  tmr_evt_sync #(.STAGES(2)) u_evt (
    .clk(clk), .rst_n(rst_n), .pin(evt_pin), .tick(tick_evt));

  assign tick_pri = pick_tick(sel_pri, tick_pre, tick_evt);
  assign tick_sec = pick_tick(sel_sec, tick_pre, tick_evt);

  tmr_alt_ctr #(.W(W)) u_pri (
    .clk(clk), .rst_n(rst_n), .stop(sel_pri == SEL_STOP), .tick(tick_pri),
    .out_en(out_en), .init_level(init_level), .rel_a(reload_a),
    .rel_b(reload_b), .pwm(pwm_out), .uf(uf_pri), .set_a(set_a),
    .set_b(set_b), .src_b(src_b));

  tmr_down_ctr #(.W(W)) u_sec (
    .clk(clk), .rst_n(rst_n), .stop(sel_sec == SEL_STOP), .tick(tick_sec),
    .rel(reload_sec), .uf(uf_sec));

  assign f_set = {uf_sec, set_b, set_a};
  assign f_clr = {clr_s, clr_b, clr_a};

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= 1'b0;
      else        q <= next_flag(q, f_set[i], f_clr[i]);
    end
    assign f_q[i] = q;
  end

  assign pend_a = f_q[0];
  assign pend_b = f_q[1];
  assign pend_s = f_q[2];
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int PW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [PW-1:0] prescale,
  input logic [2:0]    sel_pri,
  input logic          out_en,
  input logic          init_level,
  input logic          clr_a,
  input logic          tick_pre,
  input logic          uf_pri,
  input logic          uf_sec,
  input logic          set_a,
  input logic          src_b,
  input logic          pwm_out,
  input logic          pend_a,
  input logic          pend_b,
  input logic          pend_s
);
  p_prescale_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tick_pre |=> (tick_pre == (prescale == '0)));

  p_stop_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_pri == 3'b000) |=> (pwm_out == $past(init_level)));

  p_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pri && out_en) |=> (pwm_out != $past(pwm_out)));

  p_hold_pin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pri && !out_en) |=> $stable(pwm_out));

  p_alt_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pri && sel_pri != 3'b000) |=> (src_b != $past(src_b)));

  p_flag_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pri && !src_b) |=> pend_a);

  p_flag_b_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pri && src_b) |=> pend_b);

  p_flag_s_r7: assert property (@(posedge clk) disable iff (!rst_n)
    uf_sec |=> pend_s);

  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (set_a && clr_a) |=> pend_a);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_a && !clr_a) |=> pend_a);
endmodule

bind pwm_alt_timer tmr_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .prescale(prescale), .sel_pri(sel_pri),
  .out_en(out_en), .init_level(init_level), .clr_a(clr_a),
  .tick_pre(tick_pre), .uf_pri(uf_pri), .uf_sec(uf_sec), .set_a(set_a),
  .src_b(src_b), .pwm_out(pwm_out), .pend_a(pend_a), .pend_b(pend_b),
  .pend_s(pend_s));

// File: tb/sim_pwm_alt_timer.sv
`timescale 1ns/1ps
module sim_pwm_alt_timer;
  logic clk = 0, rst_n = 0;
  logic [4:0] prescale = 0;
  logic [2:0] sel_pri = 0, sel_sec = 0;
  logic evt_pin = 0;
  logic [15:0] reload_a = 0, reload_b = 0, reload_sec = 0;
  logic out_en = 0, init_level = 0, clr_a = 0, clr_b = 0, clr_s = 0;
  logic pwm_out, pend_a, pend_b, pend_s;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_alt_timer u0 (.*);

  // behavioural reference model
  int pc = 0, c1 = 0, c2 = 0;
  bit nb = 0, m_pin = 0, ma = 0, mb = 0, ms = 0;
  bit sy[$] = '{0, 0, 0};

  function automatic bit tick_of(int sel, bit tp, bit te);
    if (sel == 1) return tp;
    if (sel == 2) return te;
    return 0;
  endfunction

  always @(posedge clk) begin
    bit tp, te, t1, t2, sa, sb, ss;
    if (!rst_n) begin
      pc = 0; c1 = 0; c2 = 0; nb = 0; m_pin = 0; ma = 0; mb = 0; ms = 0;
      sy = '{0, 0, 0};
    end else begin
      tp = (pc == int'(prescale));
      pc = tp ? 0 : (pc + 1) % 32;
      te = sy[1] && !sy[2];
      sy.push_front(evt_pin); void'(sy.pop_back());
      t1 = tick_of(int'(sel_pri), tp, te);
      t2 = tick_of(int'(sel_sec), tp, te);
      sa = 0; sb = 0; ss = 0;
      if (sel_pri == 0) begin c1 = 0; nb = 0; m_pin = init_level; end
      else if (t1) begin
        if (c1 == 0) begin
          if (nb) begin c1 = int'(reload_b); sb = 1; end
          else    begin c1 = int'(reload_a); sa = 1; end
          nb = !nb;
          if (out_en) m_pin = !m_pin;
        end else c1 = c1 - 1;
      end
      if (sel_sec == 0) c2 = 0;
      else if (t2) begin
        if (c2 == 0) begin c2 = int'(reload_sec); ss = 1; end
        else c2 = c2 - 1;
      end
      ma = sa || (ma && !clr_a);
      mb = sb || (mb && !clr_b);
      ms = ss || (ms && !clr_s);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("R1 R2 R3 R4 R5 R8", "pwm_out", pwm_out, m_pin);
    chk("R6 R9", "pend_a", pend_a, ma);
    chk("R6 R9", "pend_b", pend_b, mb);
    chk("R7 R9", "pend_s", pend_s, ms);
  end

  task automatic report();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
    #0.5;
  endtask

  task automatic gap_to_toggle(output int n);
    bit prev = pwm_out;
    n = 0;
    do begin @(negedge clk); n++; end while (pwm_out == prev && n < 1000);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int g;
    cyc(3);
    // R10 reset state
    chk("R10", "reset pwm", pwm_out, 0);
    chk("R10", "reset flags", {pend_a, pend_b, pend_s}, 0);
    rst_n = 1;
    cyc(2);

    // R5 phase lengths with factor 1
    reload_a = 2; reload_b = 5; out_en = 1; init_level = 0;
    cyc(2);
    sel_pri = 1;
    gap_to_toggle(g); chk("R5", "first reload gap", g, 1);
    gap_to_toggle(g); chk("R5", "A phase cycles", g, 3);
    gap_to_toggle(g); chk("R5", "B phase cycles", g, 6);
    gap_to_toggle(g); chk("R5", "A phase again", g, 3);
    cyc(1); clr_a = 1; clr_b = 1; cyc(1); clr_a = 0; clr_b = 0;

    // R4 output enable off
    out_en = 0; cyc(40); out_en = 1; cyc(10);

    // R2 stop, level 1, restart with factor 3 (R1)
    sel_pri = 0; init_level = 1; cyc(3);
    chk("R2", "stopped level", pwm_out, 1);
    prescale = 2; sel_pri = 1; cyc(60);

    // R2 unused codes hold state
    for (int k = 3; k < 8; k++) begin sel_pri = 3'(k); cyc(8); end
    sel_pri = 1; cyc(20);

    // R7 secondary with R1 prescale factor 4
    prescale = 3; reload_sec = 1; sel_sec = 1;
    cyc(4); clr_s = 1; cyc(1); clr_s = 0;
    cyc(60);

    // R8 external events on both counters
    sel_pri = 0; sel_sec = 0; cyc(2);
    reload_a = 1; reload_b = 2; reload_sec = 2;
    sel_pri = 2; sel_sec = 2;
    for (int k = 0; k < 20; k++) begin
      evt_pin = 1; cyc(1 + k % 3); evt_pin = 0; cyc(2 + k % 2);
    end

    // R9 set and clear collide, reloads every cycle
    sel_pri = 0; sel_sec = 0; prescale = 0; reload_a = 0; reload_b = 0;
    cyc(2); sel_pri = 1; cyc(3);
    clr_a = 1; cyc(7); clr_a = 0;
    clr_b = 1; cyc(6); clr_b = 0;
    cyc(4);
    clr_a = 1; clr_b = 1; sel_pri = 0; cyc(2);
    chk("R9", "flags cleared", {pend_a, pend_b}, 0);
    clr_a = 0; clr_b = 0; cyc(4);
    report();
  end
endmodule